// File: doc/BRIEF.md
# Serial Configuration Latch Port

This block takes a 22-bit configuration word over a slow serial clock and data pair and holds it in an active register that drives the static controls of a four-bank clock divider and fanout stage. Each bank gets a 3-bit divide code. Each of the eight outputs gets an enable bit. A 2-bit output-type code is decoded into a per-bank selection between two differential output standards. The serial clock, data and load strobe are asynchronous to the system clock, so each is passed through a two-stage synchronizer first.

Bits shift in most significant first on rising serial clock edges. The load strobe works as a level: while it is high, the active register follows the shift register. While it is low, every output enable is forced off. A hardware enable input also forces all enables off, whatever the serial settings are. A readback line drives out the most significant bit of the shift register on every falling serial clock edge. As the next frame is shifted in, the word just written therefore comes back out, highest bit first. A sticky flag reports that at least one load has happened since reset.

Top module: `cfg_serial_port`

## Requirements
- R1: On each rising edge of `ser_clk`, the value on `ser_din` enters the low end of a 22-bit shift register, and every earlier bit moves up one place. The first bit sent ends up as frame bit 22 (the MSB).
- R2: While `load_en` is high, the active register copies the shift register. While `load_en` is low, the active register holds its value.
- R3: Field layout of the frame, counting bits 22..1 (bit 22 is sent first):
  - bits 22..11 are the divide codes of banks A, B, C and D, three bits each, with bank A in bits 22..20. They appear on `bank_div`, with bank A at [11:9] and bank D at [2:0].
  - bits 10..3 are the output enables. Frame bit k+3 drives `out_en[k]`.
  - bits 2..1 form `type_code`, with bit 2 as its MSB.
- R4: `bank_pecl` has one bit per bank: bit 3 is bank A and bits 2..0 are banks B..D, where 1 selects the PECL-style standard and 0 selects LVDS. The four type codes decode as follows:
  - 00 gives 0000.
  - 11 gives 1111.
  - 10 gives 0111 (A LVDS, others PECL).
  - 01 gives 1000 (A PECL, others LVDS).
- R5: While the synchronized `load_en` is low, `out_en` is all zero.
- R6: While `hw_oe` is low, `out_en` is all zero, regardless of the enable bits in the active register.
- R7: On each falling edge of `ser_clk`, `ser_dout` takes the shift register MSB. Sampled before each rising edge of the next 22-bit frame, `ser_dout` reproduces the previous frame, bit 22 first.
- R8: `cfg_valid` rises on the first cycle in which a load happens and stays high until reset. While it is low, `out_en` is zero.
- R9: After a synchronous reset, the following are all zero: the shift register, the active register, `ser_dout` and `cfg_valid`.
- R10: A frame longer than 22 bits keeps only the last 22 bits sent, and the earliest bits are lost off the top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_din | input | 1 | Serial data in, asynchronous |
| load_en | input | 1 | Level load strobe and output gate, asynchronous |
| hw_oe | input | 1 | Global hardware output enable |
| ser_dout | output | 1 | Serial readback |
| bank_div | output | 12 | Divide codes, bank A in [11:9] |
| out_en | output | 8 | Gated per-output enables |
| type_code | output | 2 | Active output-type code |
| bank_pecl | output | 4 | Decoded per-bank type select, bank A in [3] |
| cfg_valid | output | 1 | At least one load since reset |

## Verification
Every serial input passes through two synchronizer flops. A rising `ser_clk` therefore reaches the shift register on the third system clock edge after the pin changes. A falling edge reaches `ser_dout` on the third edge as well. The active register, `cfg_valid` and the gated enables respond to `load_en` on the second or third edge, and `hw_oe` gates `out_en` in the same cycle. The bench changes serial data two cycles before raising `ser_clk` and holds each clock phase for five system cycles. It waits six cycles after raising `load_en` and four after lowering it, and samples readback just before each rising serial edge. Every sample therefore lands after all of these latencies have passed.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int NUM_BANKS = 4;
    localparam int DIV_W     = 3;
    localparam int NUM_OUT   = 8;
    localparam int TYPE_W    = 2;
    localparam int FRAME_W   = NUM_BANKS * DIV_W + NUM_OUT + TYPE_W;
    localparam int SYNC_STAGES = 2;

    // Frame layout, MSB first on the wire; div[NUM_BANKS-1] is bank A.
    typedef struct packed {
        logic [NUM_BANKS-1:0][DIV_W-1:0] div;
        logic [NUM_OUT-1:0]              oe;
        logic [TYPE_W-1:0]               otype;
    } cfg_word_t;

    // One bit per bank, bank A in the top bit; 1 = PECL-style, 0 = LVDS.
    function automatic logic [NUM_BANKS-1:0] decode_type(input logic [TYPE_W-1:0] code);
        logic [NUM_BANKS-1:0] sel;
        case (code)
            2'b00: sel = '0;
            2'b11: sel = '1;
            2'b10: begin
                sel = '1;
                sel[NUM_BANKS-1] = 1'b0;
            end
            default: begin
                sel = '0;
                sel[NUM_BANKS-1] = 1'b1;
            end
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cfgp_shifter.sv
module cfgp_shifter
    import cfgp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sclk_s,
    input  logic      din_s,
    output cfg_word_t word,
    output logic      ser_dout
);
    logic [FRAME_W-1:0] shift_q;
    logic               sclk_d;
    logic               rise, fall;

    assign rise = sclk_s & ~sclk_d;
    assign fall = ~sclk_s & sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d   <= 1'b0;
            shift_q  <= '0;
            ser_dout <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            if (rise) shift_q  <= {shift_q[FRAME_W-2:0], din_s};
            if (fall) ser_dout <= shift_q[FRAME_W-1];
        end
    end

    assign word = cfg_word_t'(shift_q);

    // R1: no serial rising edge, no shift
    p_shift_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(shift_q));
    // R1: new bit lands at the low end
    p_shift_lsb_r1: assert property (@(posedge clk) disable iff (rst)
        rise |=> shift_q[0] == $past(din_s));
    // R7: readback follows MSB on falling edge
    p_readback_r7: assert property (@(posedge clk) disable iff (rst)
        fall |=> ser_dout == $past(shift_q[FRAME_W-1]));
    p_dout_stable_r7: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(ser_dout));
endmodule

// File: rtl/cfgp_latch.sv
module cfgp_latch
    import cfgp_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       le_s,
    input  logic                       hw_oe,
    input  cfg_word_t                  word,
    output logic [NUM_BANKS*DIV_W-1:0] bank_div,
    output logic [NUM_OUT-1:0]         out_en,
    output logic [TYPE_W-1:0]          type_code,
    output logic [NUM_BANKS-1:0]       bank_pecl,
    output logic                       cfg_valid
);
    cfg_word_t active_q;
    logic      gate;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q  <= '0;
            cfg_valid <= 1'b0;
        end else if (le_s) begin
            active_q  <= word;
            cfg_valid <= 1'b1;
        end
    end

    assign gate      = le_s & hw_oe & cfg_valid;
    assign out_en    = active_q.oe & {NUM_OUT{gate}};
    assign bank_div  = active_q.div;
    assign type_code = active_q.otype;
    assign bank_pecl = decode_type(active_q.otype);

    // R2: register holds while strobe low
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !le_s |=> $stable(active_q));
    // R5: strobe low disables outputs
    p_le_gate_r5: assert property (@(posedge clk) disable iff (rst)
        !le_s |-> out_en == '0);
    // R6: hardware enable overrides
    p_hw_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !hw_oe |-> out_en == '0);
    // R8: valid is sticky
    p_valid_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |=> cfg_valid);
    p_valid_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !cfg_valid |-> out_en == '0);
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
    import cfgp_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ser_clk,
    input  logic                       ser_din,
    input  logic                       load_en,
    input  logic                       hw_oe,
    output logic                       ser_dout,
    output logic [NUM_BANKS*DIV_W-1:0] bank_div,
    output logic [NUM_OUT-1:0]         out_en,
    output logic [TYPE_W-1:0]          type_code,
    output logic [NUM_BANKS-1:0]       bank_pecl,
    output logic                       cfg_valid
);
    logic [2:0] raw_in, sync_out;
    cfg_word_t  shift_word;

    assign raw_in = {ser_clk, ser_din, load_en};

    cfgp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_out)
    );

    cfgp_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .sclk_s   (sync_out[2]),
        .din_s    (sync_out[1]),
        .word     (shift_word),
        .ser_dout (ser_dout)
    );

    cfgp_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .le_s      (sync_out[0]),
        .hw_oe     (hw_oe),
        .word      (shift_word),
        .bank_div  (bank_div),
        .out_en    (out_en),
        .type_code (type_code),
        .bank_pecl (bank_pecl),
        .cfg_valid (cfg_valid)
    );

    // R9: reset clears outputs
    p_reset_r9: assert property (@(posedge clk)
        $past(rst) |-> (cfg_valid == 1'b0 && ser_dout == 1'b0 && bank_div == '0));
endmodule

// File: tb/cfg_serial_port_tb.sv
module cfg_serial_port_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0, ser_din = 1'b0, load_en = 1'b0, hw_oe = 1'b1;
    logic        ser_dout;
    logic [11:0] bank_div;
    logic [7:0]  out_en;
    logic [1:0]  type_code;
    logic [3:0]  bank_pecl;
    logic        cfg_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [21:0] model = '0;   // bench copy of what has been shifted
    logic [21:0] latched = '0;

    always #4 clk = ~clk;

    cfg_serial_port u_dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din),
        .load_en(load_en), .hw_oe(hw_oe), .ser_dout(ser_dout),
        .bank_div(bank_div), .out_en(out_en), .type_code(type_code),
        .bank_pecl(bank_pecl), .cfg_valid(cfg_valid)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_pecl(input logic [1:0] c);
        case (c)
            2'b00: return 4'b0000;
            2'b11: return 4'b1111;
            2'b10: return 4'b0111;
            default: return 4'b1000;
        endcase
    endfunction

    function automatic logic [7:0] exp_oe(input logic [21:0] w, input bit le, input bit hw, input bit v);
        return (le && hw && v) ? w[9:2] : 8'h00;
    endfunction

    task automatic send_bit(input logic b, output logic rb);
        rb = ser_dout;
        ser_din = b;
        wait_clk(2);
        ser_clk = 1'b1;
        wait_clk(5);
        ser_clk = 1'b0;
        wait_clk(5);
        model = {model[20:0], b};
    endtask

    task automatic send_frame(input logic [21:0] w, output logic [21:0] rb);
        logic r;
        for (int i = 21; i >= 0; i--) begin
            send_bit(w[i], r);
            rb[i] = r;
        end
    endtask

    task automatic write_checked(input logic [21:0] w);
        logic [21:0] rb;
        logic [21:0] prev;
        prev = model;
        send_frame(w, rb);
        check(rb == prev, "R7 readback of previous frame", 32'(rb), 32'(prev));
        check(model == w, "R1 shift model", 32'(model), 32'(w));
    endtask

    task automatic load_and_check(input string note);
        load_en = 1'b1;
        wait_clk(6);
        latched = model;
        check(bank_div == latched[21:10], "R3 divide fields", 32'(bank_div), 32'(latched[21:10]));
        check(type_code == latched[1:0], "R3 type field", 32'(type_code), 32'(latched[1:0]));
        check(bank_pecl == exp_pecl(latched[1:0]), "R4 type decode", 32'(bank_pecl), 32'(exp_pecl(latched[1:0])));
        check(out_en == exp_oe(latched, 1'b1, hw_oe, 1'b1), "R6 enables with strobe high",
              32'(out_en), 32'(exp_oe(latched, 1'b1, hw_oe, 1'b1)));
        check(cfg_valid == 1'b1, "R8 valid after load", 32'(cfg_valid), 32'd1);
        load_en = 1'b0;
        wait_clk(4);
        check(out_en == 8'h00, "R5 strobe low disables", 32'(out_en), 32'd0);
        check(bank_div == latched[21:10], "R2 hold after strobe low", 32'(bank_div), 32'(latched[21:10]));
    endtask

    initial begin
        #1600000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [21:0] w;
        logic r;
        void'($urandom(32'd1234));
        wait_clk(5);
        rst = 1'b0;
        wait_clk(1);

        // R9 reset state
        check(bank_div == 12'h0 && type_code == 2'b0, "R9 reset fields", 32'(bank_div), 32'd0);
        check(cfg_valid == 1'b0, "R9 reset valid", 32'(cfg_valid), 32'd0);
        check(ser_dout == 1'b0, "R9 reset readback", 32'(ser_dout), 32'd0);

        // R2 / R8: shift with strobe low, nothing latched
        w = {3'd1, 3'd2, 3'd5, 3'd7, 8'hA5, 2'b10};
        write_checked(w);
        check(bank_div == 12'h0, "R2 no load while strobe low", 32'(bank_div), 32'd0);
        check(cfg_valid == 1'b0, "R8 valid before first load", 32'(cfg_valid), 32'd0);
        check(out_en == 8'h00, "R8 enables off before load", 32'(out_en), 32'd0);
        load_and_check("first");
        check(cfg_valid == 1'b1, "R8 valid sticky after strobe low", 32'(cfg_valid), 32'd1);

        // R6: hardware enable override
        hw_oe = 1'b0;
        load_en = 1'b1;
        wait_clk(6);
        check(out_en == 8'h00, "R6 hw enable low", 32'(out_en), 32'd0);
        hw_oe = 1'b1;
        wait_clk(1);
        check(out_en == 8'hA5, "R6 hw enable restored", 32'(out_en), 32'hA5);
        load_en = 1'b0;
        wait_clk(4);

        // R4: all four type codes
        for (int c = 0; c < 4; c++) begin
            w = {3'd3, 3'd4, 3'd6, 3'd0, 8'hFF, 2'(c)};
            write_checked(w);
            load_and_check("type");
        end

        // random frames
        for (int n = 0; n < 20; n++) begin
            w = 22'($urandom);
            hw_oe = 1'($urandom);
            write_checked(w);
            load_and_check("random");
        end
        hw_oe = 1'b1;

        // R10: over-length frame keeps the last 22 bits
        w = {3'd2, 3'd3, 3'd4, 3'd5, 8'h3C, 2'b01};
        send_bit(1'b1, r);
        send_bit(1'b0, r);
        send_bit(1'b1, r);
        for (int i = 21; i >= 0; i--) send_bit(w[i], r);
        check(model == w, "R10 bench model last 22", 32'(model), 32'(w));
        load_en = 1'b1;
        wait_clk(6);
        check(bank_div == w[21:10], "R10 overlong frame divide", 32'(bank_div), 32'(w[21:10]));
        check(out_en == 8'h3C, "R10 overlong frame enables", 32'(out_en), 32'h3C);
        load_en = 1'b0;
        wait_clk(4);

        // R9: reset again clears valid
        rst = 1'b1;
        wait_clk(2);
        rst = 1'b0;
        wait_clk(1);
        model = '0;
        check(cfg_valid == 1'b0, "R9 reset clears valid", 32'(cfg_valid), 32'd0);
        check(bank_div == 12'h0, "R9 reset clears fields", 32'(bank_div), 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule